// File: doc/BRIEF.md
# Multi-Context Platform Interrupt Controller

This block gathers a fixed set of external interrupt sources and routes them to several hart contexts. A context is one privilege mode on one hardware thread, for example the machine mode and the supervisor mode of each core. Every source carries a programmable priority and can be set to edge or level sensing. Every context has its own enable mask, its own priority threshold and one interrupt output line.

A context takes ownership of an interrupt by reading its claim register. The read returns the ID of the highest-priority source that is pending, enabled for that context and above its threshold, and it clears that source's pending bit in the same cycle. Once the handler is done, the context writes the same ID to its complete register, and the source can then become pending again. Source ID 0 is reserved and means "nothing to serve". Software reaches all state through a simple synchronous word-addressed register port. Read data appears one cycle after the read strobe.

Top module: `irq_hub`

## Requirements
- R1: After reset every `irq_out` bit is 0, every source priority reads 0, the pending word reads 0 and every source is in level mode.
- R2: A claim returns the eligible source with the highest priority. When priorities are equal, the lowest source ID wins.
- R3: A source with priority 0 is never eligible. A source whose priority is less than or equal to a context's threshold neither drives that context's line nor is returned by its claim.
- R4: A source is eligible for a context only while its bit is set in that context's enable word (bit n stands for source ID n).
- R5: A claim read returns the source ID (0 when nothing is eligible) and clears that source's pending bit. The source stays non-pending until it is completed.
- R6: A write of ID n to a context's complete register releases source n only when 1 <= n <= NUM_SRC and source n is enabled for that context. Any other completion write has no effect.
- R7: In edge mode (mode word bit n = 1), a rising edge of source n makes it pending. Rising edges that arrive while the source is claimed are kept as one single pending event, which becomes visible when the source is completed.
- R8: In level mode (mode bit n = 0), an idle source's pending bit follows its input, starting one cycle after completion.
- R9: `irq_out[c]` is a register holding the OR of context c's eligible sources. It changes on the clock edge after the edge that changed the configuration or the pending state.
- R10: The register map uses word addresses. Address n (1..NUM_SRC) holds the priority of source n. 0x40 holds pending (read-only, bit n = source n). 0x41 holds the mode word. 0x80+c holds the enable word of context c. 0xC0+2c holds the threshold of context c. 0xC1+2c is the claim register (read) and the complete register (write) of context c. Input `src_in[i]` is source ID i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | External sources, bit i is source ID i+1 |
| irq_out | output | NUM_CTX | Interrupt line per context |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a claim read has side effects) |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |

## Verification
The hardest state to reach is an edge source that receives several new rising edges while it is claimed. Those edges must collapse into exactly one deferred event, and that event must appear only on completion. The bench claims an edge source on one context, pulses the input twice while the claim is held, and checks that both the pending word and the line stay quiet. After the completion it checks that exactly one further claim returns the ID and that the claim after that returns 0. A completion issued from a context that does not enable the source is checked the same way. The bench reads the pending word to confirm that the completion is ignored until the owning context completes.

// File: rtl/irq_hub_pkg.sv
// Package: register map constants shared by the controller and its bench.
// Assumes word addressing with an 8-bit address and 32-bit data.
package irq_hub_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam logic [ADDR_W-1:0] PEND_ADDR = 8'h40;
    localparam logic [ADDR_W-1:0] MODE_ADDR = 8'h41;
    localparam logic [ADDR_W-1:0] EN_BASE   = 8'h80;
    localparam logic [ADDR_W-1:0] THR_BASE  = 8'hC0;
    localparam logic [ADDR_W-1:0] CLM_BASE  = 8'hC1;
endpackage

// File: rtl/irq_hub_gate.sv
// Module: per-source gateway. It turns a raw input into a pending bit
// according to the edge/level mode and tracks whether the source is
// claimed. Assumes claim only arrives while pending is set, and that
// complete is a single-cycle pulse already qualified by the caller.
module irq_hub_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic edge_mode,
    input  logic claim,
    input  logic complete,
    output logic pend,
    output logic busy
);
    logic src_q;
    logic held;
    logic rise;

    // Rising-edge detect against the previous sample.
    assign rise = src & ~src_q;

    // Pending, in-service and deferred-edge state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            pend  <= 1'b0;
            busy  <= 1'b0;
            held  <= 1'b0;
        end else begin
            src_q <= src;
            if (claim)
                busy <= 1'b1;
            else if (complete && busy)
                busy <= 1'b0;
            if (edge_mode) begin
                if (claim) begin
                    pend <= 1'b0;
                    held <= held | rise;
                end else if (complete && busy) begin
                    pend <= held | rise;
                    held <= 1'b0;
                end else if (rise) begin
                    if (busy) held <= 1'b1;
                    else      pend <= 1'b1;
                end
            end else begin
                held <= 1'b0;
                if (claim) pend <= 1'b0;
                else       pend <= busy ? 1'b0 : src;
            end
        end
    end
endmodule

// File: rtl/irq_hub_pick.sv
// Module: per-context selector. It finds the eligible source with the
// highest priority above the threshold, and the lowest ID on a tie.
// Purely combinational. Bit s of the vectors is source ID s+1.
module irq_hub_pick #(
    parameter int NUM_SRC = 10,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thr,
    output logic [ID_W-1:0]           best_id,
    output logic                      any
);
    // Linear scan: a strictly greater priority replaces the current best.
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        logic [PRIO_W-1:0] p;
        best_p  = '0;
        best_id = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            p = prio_flat[s*PRIO_W +: PRIO_W];
            if (pend[s] && en[s] && (p > thr) && (p > best_p)) begin
                best_p  = p;
                best_id = ID_W'(s + 1);
            end
        end
        any = (best_id != '0);
    end
endmodule

// File: rtl/irq_hub.sv
// Module: top of the multi-context interrupt controller. It holds the
// configuration registers, one gateway per source, one selector and one
// registered output line per context, and the claim/complete decode.
// Assumes NUM_SRC <= 31 and NUM_CTX <= 16 so the register map fits.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_CTX-1:0] irq_out,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    localparam int ID_W = $clog2(NUM_SRC + 1);

    logic [PRIO_W-1:0]        prio_q [NUM_SRC];
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]       mode_q;
    logic [NUM_SRC-1:0]       en_q   [NUM_CTX];
    logic [PRIO_W-1:0]        thr_q  [NUM_CTX];
    logic [NUM_SRC-1:0]       pend_vec;
    logic [NUM_SRC-1:0]       busy_vec;
    logic [NUM_SRC-1:0]       claim_vec;
    logic [NUM_SRC-1:0]       done_vec;
    logic [ID_W-1:0]          best_id [NUM_CTX];
    logic [NUM_CTX-1:0]       any_vec;
    logic [NUM_CTX-1:0]       claim_hit;
    logic [NUM_CTX-1:0]       done_hit;
    logic [DATA_W-1:0]        rd_mux;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (reg_we) begin
            for (int s = 0; s < NUM_SRC; s++)
                if (reg_addr == ADDR_W'(s + 1)) prio_q[s] <= reg_wdata[PRIO_W-1:0];
            if (reg_addr == MODE_ADDR) mode_q <= reg_wdata[NUM_SRC:1];
            for (int c = 0; c < NUM_CTX; c++) begin
                if (reg_addr == EN_BASE + ADDR_W'(c))     en_q[c]  <= reg_wdata[NUM_SRC:1];
                if (reg_addr == THR_BASE + ADDR_W'(2 * c)) thr_q[c] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    // Per-context claim read and complete write strobes.
    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            claim_hit[c] = reg_re && (reg_addr == CLM_BASE + ADDR_W'(2 * c));
            done_hit[c]  = reg_we && (reg_addr == CLM_BASE + ADDR_W'(2 * c));
        end
    end

    // Fan claim and qualified completion out to the sources.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            claim_vec[s] = 1'b0;
            done_vec[s]  = 1'b0;
            for (int c = 0; c < NUM_CTX; c++) begin
                if (claim_hit[c] && best_id[c] == ID_W'(s + 1)) claim_vec[s] = 1'b1;
                if (done_hit[c] && en_q[c][s] && reg_wdata == DATA_W'(s + 1)) done_vec[s] = 1'b1;
            end
        end
    end

    genvar gs, gc;
    generate
        for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
            assign prio_flat[gs*PRIO_W +: PRIO_W] = prio_q[gs];
            irq_hub_gate u_gate (
                .clk       (clk),
                .rst_n     (rst_n),
                .src       (src_in[gs]),
                .edge_mode (mode_q[gs]),
                .claim     (claim_vec[gs]),
                .complete  (done_vec[gs]),
                .pend      (pend_vec[gs]),
                .busy      (busy_vec[gs])
            );
        end
        for (gc = 0; gc < NUM_CTX; gc++) begin : g_ctx
            irq_hub_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
                .pend      (pend_vec),
                .en        (en_q[gc]),
                .prio_flat (prio_flat),
                .thr       (thr_q[gc]),
                .best_id   (best_id[gc]),
                .any       (any_vec[gc])
            );
        end
    endgenerate

    // Registered interrupt lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= any_vec;
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (reg_addr == ADDR_W'(s + 1)) rd_mux = DATA_W'(prio_q[s]);
        if (reg_addr == PEND_ADDR) rd_mux = DATA_W'({pend_vec, 1'b0});
        if (reg_addr == MODE_ADDR) rd_mux = DATA_W'({mode_q, 1'b0});
        for (int c = 0; c < NUM_CTX; c++) begin
            if (reg_addr == EN_BASE + ADDR_W'(c))      rd_mux = DATA_W'({en_q[c], 1'b0});
            if (reg_addr == THR_BASE + ADDR_W'(2 * c)) rd_mux = DATA_W'(thr_q[c]);
            if (reg_addr == CLM_BASE + ADDR_W'(2 * c)) rd_mux = DATA_W'(best_id[c]);
        end
    end

    // Read data register, valid one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/irq_hub_chk.sv
// Module: assertion checker for irq_hub, attached through bind.
// It observes the outputs and the per-source gateway state.
module irq_hub_chk #(
    parameter int NUM_SRC = 10,
    parameter int NUM_CTX = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CTX-1:0] irq_out,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] busy,
    input logic [NUM_SRC-1:0] claim,
    input logic [NUM_CTX-1:0] any_elig
);
    // R1: the lines are low on the edge after a reset cycle.
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (irq_out == '0));

    // R9: each line equals the eligibility seen one edge earlier.
    a_r9_line_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(any_elig));

    // R2: at most one source is claimed per cycle.
    a_r2_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim));

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_chk
            // R5: a claimed source is not pending on the next cycle.
            a_r5_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
                claim[s] |=> (!pend[s] && busy[s]));
            // R5: a source in service is never pending at the same time.
            a_r5_no_pend_in_service: assert property (@(posedge clk) disable iff (!rst_n)
                !(pend[s] && busy[s]));
            // R5: a source only enters service after it was pending.
            a_r5_service_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(busy[s]) |-> $past(pend[s]));
        end
    endgenerate
endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .pend     (pend_vec),
    .busy     (busy_vec),
    .claim    (claim_vec),
    .any_elig (any_vec)
);

// File: tb/irq_hub_bench.sv
// Bench: a table walk of level-source patterns on context 0, then
// directed tests for reset, thresholds, enables, completion and edges.
module irq_hub_bench;
    import irq_hub_pkg::*;
    localparam int NS = 10;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic [NC-1:0] irq_out;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .irq_out(irq_out),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Each entry: {source mask by ID bit, expected claim ID}. The priority of ID i is (i*5)%8, threshold 1.
    localparam logic [23:0] VEC [10] = '{
        {16'h0002, 8'd1}, {16'h000C, 8'd3}, {16'h0402, 8'd1}, {16'h0222, 8'd1},
        {16'h0200, 8'd9}, {16'h0100, 8'd0}, {16'h0020, 8'd0}, {16'h0048, 8'd3},
        {16'h0050, 8'd6}, {16'h07FE, 8'd3}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 irq", 32'(irq_out), 0);
        rd(8'h03, d); check("R1 prio", d, 0);
        rd(PEND_ADDR, d); check("R1 pend", d, 0);
        rd(MODE_ADDR, d); check("R1 mode", d, 0);

        for (int i = 1; i <= NS; i++) wr(8'(i), 32'((i * 5) % 8));
        wr(THR_BASE, 1);
        wr(EN_BASE, 32'h7FE);
        rd(8'h03, d); check("R10 prio readback", d, 7);
        rd(EN_BASE, d); check("R10 enable readback", d, 32'h7FE);

        // R2 R3 R5 R8 table walk on context 0 with level sources
        for (int v = 0; v < 10; v++) begin
            logic [15:0] m;
            logic [7:0]  e;
            {m, e} = VEC[v];
            src_in = m[NS:1];
            step(3);
            check("R3 R2 line", 32'(irq_out[0]), 32'(e != 0));
            rd(CLM_BASE, d);
            check("R2 R5 claim id", d, 32'(e));
            src_in = '0;
            if (e != 0) wr(CLM_BASE, 32'(e));
            step(3);
            rd(PEND_ADDR, d); check("R8 pend follows input low", d, 0);
        end

        // R3 threshold equal masks, R9 timing
        src_in[2] = 1'b1;               // ID 3, priority 7
        wr(THR_BASE, 7);
        step(3);
        check("R3 equal threshold masked", 32'(irq_out[0]), 0);
        rd(CLM_BASE, d); check("R3 equal threshold claim", d, 0);
        wr(THR_BASE, 6);
        check("R9 line not yet updated", 32'(irq_out[0]), 0);
        step(1);
        check("R9 line one cycle later", 32'(irq_out[0]), 1);

        // R4 context 1 enables only ID 4
        wr(EN_BASE + 8'd1, 32'h010);
        wr(THR_BASE + 8'd2, 0);
        step(2);
        check("R4 other ctx line low", 32'(irq_out[1]), 0);
        rd(CLM_BASE + 8'd2, d); check("R4 other ctx claim empty", d, 0);

        // R6 completion from a context that does not enable ID 3 is ignored
        rd(CLM_BASE, d); check("R5 claim ID 3", d, 3);
        wr(CLM_BASE + 8'd2, 3);
        step(3);
        rd(PEND_ADDR, d); check("R6 foreign complete ignored", d, 0);
        wr(CLM_BASE, 32'd12);
        step(3);
        rd(PEND_ADDR, d); check("R6 out-of-range complete ignored", d, 0);
        wr(CLM_BASE, 3);
        step(3);
        rd(PEND_ADDR, d); check("R6 R8 complete re-arms level", d, 32'h008);
        src_in = '0;
        step(3);
        rd(PEND_ADDR, d); check("R8 level pending drops", d, 0);

        // R7 edge mode on ID 4 via context 1
        wr(MODE_ADDR, 32'h010);
        src_in[3] = 1'b1; step(1); src_in[3] = 1'b0;
        step(3);
        check("R7 edge raises line", 32'(irq_out[1]), 1);
        rd(CLM_BASE + 8'd2, d); check("R7 claim edge source", d, 4);
        src_in[3] = 1'b1; step(1); src_in[3] = 1'b0; step(2);
        src_in[3] = 1'b1; step(1); src_in[3] = 1'b0; step(3);
        rd(PEND_ADDR, d); check("R7 edges held while claimed", d, 0);
        check("R7 line quiet while claimed", 32'(irq_out[1]), 0);
        wr(CLM_BASE + 8'd2, 4);
        step(3);
        check("R7 deferred event after complete", 32'(irq_out[1]), 1);
        rd(CLM_BASE + 8'd2, d); check("R7 second claim", d, 4);
        wr(CLM_BASE + 8'd2, 4);
        step(3);
        rd(CLM_BASE + 8'd2, d); check("R7 R5 single event then empty", d, 0);
        check("R7 line low at end", 32'(irq_out[1]), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule